// File: doc/BRIEF.md
# Write-Protect Status Register Controller

This block holds an 8-bit volatile status word that decides whether host writes to the clock/control registers and to the memory array are accepted. Two enable latches must be opened in a fixed order by exact byte patterns written to the status word. The first latch opens the array. Both latches together open the clock/control registers. The word also reports a power-fail flag, a battery indicator and two sticky alarm flags.

The host gives each data write a target select and receives a registered accept or ignore verdict for it. A status read is framed by a start strobe, which captures the word and returns it one cycle later, and a completion strobe. The completion strobe clears only the alarm flags that were set when the read began. Hardware drives a power-up event, a battery-mode level and one match pulse per alarm. The bus protocol and the storage behind the gate belong to other blocks.

Top module: `wp_status_ctrl`

## Requirements
- R1: A status read returns bit7 battery, bit6 alarm 1, bit5 alarm 0, bit2 register-unlock latch, bit1 write-enable latch, bit0 power-fail flag. Bits 4 and 3 always read 0. `rd_data` is valid in the cycle after `rd_start`, marked by `rd_valid`.
- R2: After `rst` or a `pwr_up_evt` pulse, both latches are 0 and the power-fail flag is 1. A write in the same cycle as `pwr_up_evt` is ignored.
- R3: A status write (`wr_tgt`=00) of 8'h02 is accepted. It sets the write-enable latch and clears the unlock latch. A status write of 8'h00 is accepted and clears both latches.
- R4: A status write of 8'h06 is accepted and sets both latches only if the write-enable latch is already 1. Otherwise it is ignored. The unlock latch is never 1 while the write-enable latch is 0.
- R5: A status write with any other byte value is ignored and changes no state.
- R6: An array write (`wr_tgt`=10) is accepted exactly when the write-enable latch is 1.
- R7: A clock/control write (`wr_tgt`=01) is accepted exactly when both latches are 1. A write to `wr_tgt`=11 is always ignored.
- R8: An accepted clock/control write clears the power-fail flag. Ignored writes and writes to other targets leave it unchanged.
- R9: A pulse on `alm_match[i]` sets alarm flag i. The flag stays set until a read completion clears it.
- R10: `rd_done` clears only the alarm flags that were set when the preceding `rd_start` was seen. A match arriving after that start, including one in the `rd_done` cycle, leaves its flag set.
- R11: The battery bit equals `batt_mode` as sampled on the previous clock edge.
- R12: Each `wr_en` cycle yields exactly one of `wr_ack` or `wr_ign`, one cycle later. The verdict uses the latch state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up_evt | input | 1 | Pulse: power restored after total loss |
| batt_mode | input | 1 | Level: running from backup supply |
| alm_match | input | 2 | Per-alarm match pulses |
| wr_en | input | 1 | Data write strobe |
| wr_tgt | input | 2 | Write target: 00 status, 01 clock/control, 10 array, 11 reserved |
| wr_data | input | 8 | Write byte |
| wr_ack | output | 1 | Write accepted (registered) |
| wr_ign | output | 1 | Write ignored (registered) |
| rd_start | input | 1 | Status read begins; word captured |
| rd_done | input | 1 | Status read completed |
| rd_valid | output | 1 | `rd_data` valid |
| rd_data | output | 8 | Captured status word |

## Verification
A behavioural model runs against the block on every cycle. Directed stimulus covers the unlock ladder in the right order, in the wrong order, and with near-miss bytes such as 03, 12 and FF. These separate exact-pattern decoding from bit-wise decoding. Alarm pulses are placed before a read, inside a read window and on the completion cycle, which tells snapshot clearing apart from plain clear-on-read. A random phase then mixes power-up events, battery toggles and all four targets to reach priority interactions such as a write landing on a power-up cycle.

// File: rtl/wp_status_pkg.sv
package wp_status_pkg;
  localparam int SR_W      = 8;
  localparam int ALARM_N   = 2;
  localparam int ALARM_LSB = 5;
  localparam int BIT_BAT   = 7;
  localparam int BIT_RWEL  = 2;
  localparam int BIT_WEL   = 1;
  localparam int BIT_RTCF  = 0;

  typedef enum logic [1:0] {
    TGT_STATUS = 2'b00,
    TGT_CLOCK  = 2'b01,
    TGT_ARRAY  = 2'b10,
    TGT_RSVD   = 2'b11
  } wr_tgt_e;

  localparam logic [SR_W-1:0] PAT_LOCK   = 8'h00;
  localparam logic [SR_W-1:0] PAT_WEL    = 8'h02;
  localparam logic [SR_W-1:0] PAT_UNLOCK = 8'h06;
endpackage

// File: rtl/wp_latch_ctrl.sv
module wp_latch_ctrl
  import wp_status_pkg::*;
#(
  parameter int DW = SR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_up_evt,
  input  logic          wr_en,
  input  logic [1:0]    wr_tgt,
  input  logic [DW-1:0] wr_data,
  output logic          wel_q,
  output logic          rwel_q,
  output logic          rtcf_q,
  output logic          wr_ack_q,
  output logic          wr_ign_q
);
  logic is_stat, is_clk, is_arr;
  logic stat_ok, clk_ok, arr_ok, accept;
  logic wel_d, rwel_d, rtcf_d;

  always_comb begin
    is_stat = (wr_tgt == TGT_STATUS);
    is_clk  = (wr_tgt == TGT_CLOCK);
    is_arr  = (wr_tgt == TGT_ARRAY);
    stat_ok = is_stat && ((wr_data == PAT_LOCK) || (wr_data == PAT_WEL) ||
                          ((wr_data == PAT_UNLOCK) && wel_q));
    clk_ok  = is_clk && wel_q && rwel_q;
    arr_ok  = is_arr && wel_q;
    accept  = wr_en && !pwr_up_evt && (stat_ok || clk_ok || arr_ok);
    wel_d   = wel_q;
    rwel_d  = rwel_q;
    rtcf_d  = rtcf_q;
    if (pwr_up_evt) begin
      wel_d  = 1'b0;
      rwel_d = 1'b0;
      rtcf_d = 1'b1;
    end else if (accept) begin
      if (is_stat) begin
        wel_d  = wr_data[BIT_WEL];
        rwel_d = wr_data[BIT_RWEL];
      end
      if (is_clk) rtcf_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q    <= 1'b0;
      rwel_q   <= 1'b0;
      rtcf_q   <= 1'b1;
      wr_ack_q <= 1'b0;
      wr_ign_q <= 1'b0;
    end else begin
      wel_q    <= wel_d;
      rwel_q   <= rwel_d;
      rtcf_q   <= rtcf_d;
      wr_ack_q <= accept;
      wr_ign_q <= wr_en && !accept;
    end
  end

  AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    rwel_q |-> wel_q); // R4
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) == (wr_ack_q ^ wr_ign_q)); // R12
  AST_CLK_ACK_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_ack_q && $past(wr_tgt) == TGT_CLOCK) |-> $past(wel_q && rwel_q)); // R7
  AST_ARR_ACK_WEL: assert property (@(posedge clk) disable iff (rst)
    (wr_ack_q && $past(wr_tgt) == TGT_ARRAY) |-> $past(wel_q)); // R6
  AST_RTCF_FALL_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(rtcf_q) |-> (wr_ack_q && $past(wr_tgt) == TGT_CLOCK)); // R8
  AST_PWR_UP_STATE: assert property (@(posedge clk) disable iff (rst)
    pwr_up_evt |=> (rtcf_q && !wel_q && !rwel_q && !wr_ack_q)); // R2
endmodule

// File: rtl/wp_alarm_flags.sv
module wp_alarm_flags
  import wp_status_pkg::*;
#(
  parameter int NA = ALARM_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NA-1:0] alm_match,
  input  logic          rd_start,
  input  logic          rd_done,
  output logic [NA-1:0] flags_q
);
  logic [NA-1:0] snap_q;

  for (genvar i = 0; i < NA; i++) begin : g_alarm
    always_ff @(posedge clk) begin
      if (rst) begin
        flags_q[i] <= 1'b0;
        snap_q[i]  <= 1'b0;
      end else begin
        flags_q[i] <= (flags_q[i] && !(rd_done && snap_q[i])) || alm_match[i];
        if (rd_start)     snap_q[i] <= flags_q[i];
        else if (rd_done) snap_q[i] <= 1'b0;
      end
    end

    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
      alm_match[i] |=> flags_q[i]); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flags_q[i] && !rd_done) |=> flags_q[i]); // R9
    AST_SNAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (rd_done && !rd_start && snap_q[i] && !alm_match[i]) |=> !flags_q[i]); // R10
  end
endmodule

// File: rtl/wp_status_rd.sv
module wp_status_rd
  import wp_status_pkg::*;
#(
  parameter int DW = SR_W,
  parameter int NA = ALARM_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_start,
  input  logic          batt_mode,
  input  logic          wel,
  input  logic          rwel,
  input  logic          rtcf,
  input  logic [NA-1:0] flags,
  output logic          rd_valid_q,
  output logic [DW-1:0] rdata_q
);
  logic          bat_q;
  logic [DW-1:0] sr_word;

  always_comb begin
    sr_word                      = '0;
    sr_word[BIT_BAT]             = bat_q;
    sr_word[ALARM_LSB +: NA]     = flags;
    sr_word[BIT_RWEL]            = rwel;
    sr_word[BIT_WEL]             = wel;
    sr_word[BIT_RTCF]            = rtcf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bat_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      bat_q      <= batt_mode;
      rd_valid_q <= rd_start;
      if (rd_start) rdata_q <= sr_word;
    end
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid_q |-> (rdata_q[4:3] == 2'b00)); // R1
  AST_BAT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (rd_start && !$past(rst)) |=> (rdata_q[BIT_BAT] == $past(batt_mode, 2))); // R11
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
  import wp_status_pkg::*;
#(
  parameter int DW = SR_W,
  parameter int NA = ALARM_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_up_evt,
  input  logic          batt_mode,
  input  logic [NA-1:0] alm_match,
  input  logic          wr_en,
  input  logic [1:0]    wr_tgt,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ack,
  output logic          wr_ign,
  input  logic          rd_start,
  input  logic          rd_done,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic          wel, rwel, rtcf;
  logic [NA-1:0] flags;

  wp_latch_ctrl #(.DW(DW)) latch_i (
    .clk(clk), .rst(rst), .pwr_up_evt(pwr_up_evt),
    .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_data(wr_data),
    .wel_q(wel), .rwel_q(rwel), .rtcf_q(rtcf),
    .wr_ack_q(wr_ack), .wr_ign_q(wr_ign)
  );

  wp_alarm_flags #(.NA(NA)) alarm_i (
    .clk(clk), .rst(rst), .alm_match(alm_match),
    .rd_start(rd_start), .rd_done(rd_done), .flags_q(flags)
  );

  wp_status_rd #(.DW(DW), .NA(NA)) rd_i (
    .clk(clk), .rst(rst), .rd_start(rd_start), .batt_mode(batt_mode),
    .wel(wel), .rwel(rwel), .rtcf(rtcf), .flags(flags),
    .rd_valid_q(rd_valid), .rdata_q(rd_data)
  );
endmodule

// File: tb/wp_status_ctrl_tb.sv
module wp_status_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_up_evt = 1'b0, batt_mode = 1'b0;
  logic [1:0] alm_match = 2'b00;
  logic       wr_en = 1'b0;
  logic [1:0] wr_tgt = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic       rd_start = 1'b0, rd_done = 1'b0;
  logic       wr_ack, wr_ign, rd_valid;
  logic [7:0] rd_data;

  int checks = 0, failures = 0;
  bit finished = 0;

  // model state
  bit m_wel = 0, m_rwel = 0, m_rtcf = 1, m_bat = 0;
  bit m_al[2] = '{0, 0};
  bit m_snap[2] = '{0, 0};
  bit e_ack = 0, e_ign = 0, e_valid = 0;
  int e_rdata = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_status_ctrl dut_i (
    .clk(clk), .rst(rst), .pwr_up_evt(pwr_up_evt), .batt_mode(batt_mode),
    .alm_match(alm_match), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_ign(wr_ign), .rd_start(rd_start), .rd_done(rd_done),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int word();
    return (int'(m_bat) << 7) | (int'(m_al[1]) << 6) | (int'(m_al[0]) << 5) |
           (int'(m_rwel) << 2) | (int'(m_wel) << 1) | int'(m_rtcf);
  endfunction

  // One clock: drive at negedge, advance model, compare at next negedge.
  task automatic cyc(input bit we, input bit [1:0] tg, input bit [7:0] wd,
                     input bit rs, input bit rdn, input bit [1:0] am,
                     input bit pu, input bit bm, input string tag);
    bit acc;
    bit nal[2];
    acc = 0;
    if (we && !pu) begin
      case (tg)
        2'b00: acc = (wd == 8'h00) || (wd == 8'h02) || (wd == 8'h06 && m_wel);
        2'b01: acc = m_wel && m_rwel;
        2'b10: acc = m_wel;
        default: acc = 0;
      endcase
    end
    e_ack = acc;
    e_ign = we && !acc;
    e_valid = rs;
    if (rs) e_rdata = word();
    for (int i = 0; i < 2; i++) begin
      nal[i] = (m_al[i] && !(rdn && m_snap[i])) || am[i];
      m_snap[i] = rs ? m_al[i] : (rdn ? 1'b0 : m_snap[i]);
    end
    m_al = nal;
    if (pu) begin
      m_wel = 0; m_rwel = 0; m_rtcf = 1;
    end else if (acc) begin
      if (tg == 2'b00) begin m_wel = wd[1]; m_rwel = wd[2]; end
      if (tg == 2'b01) m_rtcf = 0;
    end
    m_bat = bm;
    wr_en = we; wr_tgt = tg; wr_data = wd; rd_start = rs; rd_done = rdn;
    alm_match = am; pwr_up_evt = pu; batt_mode = bm;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "wr_ack", int'(wr_ack), int'(e_ack));
    chk(tag, "wr_ign", int'(wr_ign), int'(e_ign));
    chk(tag, "rd_valid", int'(rd_valid), int'(e_valid));
    if (e_valid) chk(tag, "rd_data", int'(rd_data), e_rdata);
  endtask

  task automatic idle(input string tag);
    cyc(0, 2'b00, 8'h00, 0, 0, 2'b00, 0, batt_mode, tag);
  endtask
  task automatic wr(input bit [1:0] tg, input bit [7:0] wd, input string tag);
    cyc(1, tg, wd, 0, 0, 2'b00, 0, batt_mode, tag);
  endtask
  task automatic rd(input string tag);
    cyc(0, 2'b00, 8'h00, 1, 0, 2'b00, 0, batt_mode, tag);
    cyc(0, 2'b00, 8'h00, 0, 1, 2'b00, 0, batt_mode, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R12 watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset state, outputs quiet
    chk("R2", "wr_ack", int'(wr_ack), 0);
    chk("R2", "rd_valid", int'(rd_valid), 0);
    rd("R2");                          // expect 01
    wr(2'b10, 8'h55, "R6");            // array locked
    wr(2'b01, 8'h11, "R7");            // clock locked
    wr(2'b11, 8'h00, "R7");            // reserved target
    wr(2'b00, 8'h06, "R4");            // out of order
    rd("R8");                          // rtcf still 1, latches 0
    wr(2'b00, 8'h02, "R3");
    rd("R3");                          // 03
    wr(2'b10, 8'hAA, "R6");
    wr(2'b01, 8'h22, "R7");            // only WEL set
    wr(2'b00, 8'h03, "R5");
    wr(2'b00, 8'h12, "R5");
    wr(2'b00, 8'hFF, "R5");
    wr(2'b00, 8'h04, "R5");
    rd("R5");                          // still 03
    wr(2'b00, 8'h06, "R4");
    rd("R4");                          // 07
    wr(2'b01, 8'h33, "R8");            // accepted, clears rtcf
    rd("R8");                          // 06
    wr(2'b00, 8'h02, "R3");            // drops RWEL
    wr(2'b01, 8'h44, "R7");
    wr(2'b00, 8'h00, "R3");
    rd("R1");                          // 00
    wr(2'b10, 8'h01, "R6");
    cyc(0, 2'b00, 8'h00, 0, 0, 2'b00, 0, 1, "R11");
    rd("R11");                         // 80
    // alarm snapshot
    cyc(0, 2'b00, 8'h00, 0, 0, 2'b01, 0, 1, "R9");
    idle("R9");
    cyc(0, 2'b00, 8'h00, 1, 0, 2'b00, 0, 1, "R10");   // snap al0
    cyc(0, 2'b00, 8'h00, 0, 0, 2'b10, 0, 1, "R10");   // al1 during read
    cyc(0, 2'b00, 8'h00, 0, 1, 2'b00, 0, 1, "R10");
    rd("R10");                                        // al1 kept -> c0, then cleared
    cyc(0, 2'b00, 8'h00, 1, 0, 2'b00, 0, 0, "R10");
    cyc(0, 2'b00, 8'h00, 0, 1, 2'b01, 0, 0, "R10");   // match on done cycle
    rd("R10");
    rd("R1");
    // power-up event with a colliding write
    wr(2'b00, 8'h02, "R3");
    wr(2'b00, 8'h06, "R4");
    cyc(1, 2'b01, 8'h00, 0, 0, 2'b00, 1, 0, "R2");
    rd("R2");
    wr(2'b01, 8'h00, "R2");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit [7:0] wd;
      bit rs, rdn, pu, bm;
      bit [1:0] am;
      case ($urandom % 4)
        0: wd = 8'h00;
        1: wd = 8'h02;
        2: wd = 8'h06;
        default: wd = 8'($urandom);
      endcase
      rs  = ($urandom % 6) == 0;
      rdn = !rs && (($urandom % 6) == 0);
      am  = {($urandom % 16) == 0, ($urandom % 16) == 0};
      pu  = ($urandom % 150) == 0;
      bm  = (($urandom % 40) == 0) ? !batt_mode : batt_mode;
      cyc(($urandom % 2) == 0, 2'($urandom), wd, rs, rdn, am, pu, bm, "R12");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule